// File: doc/BRIEF.md
# Position Compare Sync Pulse Generator

This block watches a 32-bit position count and compares it against a programmable compare value. When the count first reaches that value, the block signals a one-cycle match event. It also drives a sync output pulse whose length is set by a 12-bit width field and whose active level is programmable.

The compare value can be written in two ways. A direct write updates the live compare value at once. A shadowed write parks the value in a holding register. The holding register is copied into the live compare value when the selected load event occurs: either the count reaching zero, or a compare match. Every such copy raises a one-cycle ready event.

A single enable switches the whole function on or off. Pin routing and interrupt aggregation are handled outside this block.

Top module: `pos_cmp_sync`

## Requirements
- R1: With `shadow_en_i`=0, a write (`cmp_wr_i`=1) makes `cmp_active_o` equal `cmp_wdata_i` after the next clock edge. This holds even when a shadow transfer is pending; the pending transfer is dropped.
- R2: With `shadow_en_i`=1, a write only fills the holding register. `cmp_active_o` keeps its value until a transfer occurs.
- R3: With `load_mode_i`=0, a pending shadow value moves to `cmp_active_o` on the clock edge at which `count_i`==0 while `en_i`=1. A pending value does not move on a compare match in this mode.
- R4: With `load_mode_i`=1, a pending shadow value moves to `cmp_active_o` on the same edge that produces a compare match. A pending value does not move at count zero in this mode.
- R5: `ready_o` is high for exactly the one cycle after each shadow-to-active transfer, and at no other time.
- R6: `match_o` rises one cycle after the first edge at which `count_i` equals `cmp_active_o`. It is not raised again while that equality persists.
- R7: `sync_o` is active for exactly (`width_i`+1)×4 clock cycles, starting in the same cycle as `match_o`. The pulse continues even if the count moves on.
- R8: `sync_o` is active-high when `pol_i`=0 and active-low when `pol_i`=1. The inactive level is the value of `pol_i`.
- R9: A match during an active pulse restarts the full length. The pulse then ends (`width_i`+1)×4 cycles after the second match.
- R10: While `en_i`=0, on the following cycle `match_o` and `ready_o` stay low and `sync_o` is at its inactive level. Any pulse in progress is cut short, and no shadow transfer occurs.
- R11: After reset, `cmp_active_o`=0, and `match_o`, `ready_o` and the internal pulse state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Compare function enable |
| shadow_en_i | input | 1 | 1: writes go to the holding register; 0: writes go directly to the live compare value |
| load_mode_i | input | 1 | Shadow load event: 0 = count zero, 1 = compare match |
| pol_i | input | 1 | Sync output polarity: 0 = active-high, 1 = active-low |
| width_i | input | 12 | Sync pulse width field |
| count_i | input | 32 | Live position count |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 32 | Compare write data |
| cmp_active_o | output | 32 | Live compare value |
| match_o | output | 1 | One-cycle compare match event |
| ready_o | output | 1 | One-cycle shadow transfer event |
| sync_o | output | 1 | Sync output pulse |

## Verification
A stale or corrupted compare value appears at `cmp_active_o` one cycle after the faulty write or transfer. It also shows as a missing or misplaced `match_o` at the next equality. A lost or stuck pending flag shows as a missing or spurious `ready_o` at the next count-zero or match event. A miscounted pulse register is exposed by measuring `sync_o` length across a sweep of widths, in both polarities, and across a mid-pulse retrigger. The length error becomes visible at the last cycle of the pulse, no more than (width+1)×4 cycles after the match.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic {
    LOAD_AT_ZERO  = 1'b0,
    LOAD_AT_MATCH = 1'b1
  } load_mode_e;
endpackage

// File: rtl/pcs_cmp_reg.sv
module pcs_cmp_reg #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             shadow_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             xfer_req_i,
  output logic             xfer_o,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] shadow_q;
  logic             pending_q;
  logic             direct_wr;

  assign direct_wr = wr_i & ~shadow_en_i;
  // a direct write wins over a pending transfer
  assign xfer_o    = xfer_req_i & pending_q & ~direct_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= '0;
      shadow_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (direct_wr) begin
        active_o  <= wdata_i;
        pending_q <= 1'b0;
      end else if (xfer_o) begin
        active_o  <= shadow_q;
        pending_q <= 1'b0;
      end
      if (wr_i && shadow_en_i) begin
        shadow_q  <= wdata_i;
        pending_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcs_match_det.sv
module pcs_match_det #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] active_i,
  output logic             hit_o,
  output logic             match_o
);
  logic eq, eq_q;

  assign eq    = (count_i == active_i);
  assign hit_o = en_i & eq & ~eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q    <= 1'b0;
      match_o <= 1'b0;
    end else begin
      eq_q    <= en_i & eq;
      match_o <= hit_o;
    end
  end
endmodule

// File: rtl/pcs_pulse_gen.sv
module pcs_pulse_gen #(
  parameter int WID_W   = 12,
  parameter int TICK_LG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             pol_i,
  output logic             sync_o
);
  localparam int REM_W = WID_W + TICK_LG + 1;

  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] len;

  assign len    = (REM_W'(width_i) + REM_W'(1)) << TICK_LG;
  assign sync_o = (rem_q != '0) ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rem_q <= '0;
    else if (!en_i)          rem_q <= '0;
    else if (trig_i)         rem_q <= len;
    else if (rem_q != '0)    rem_q <= rem_q - REM_W'(1);
  end
endmodule

// File: rtl/pos_cmp_sync.sv
module pos_cmp_sync #(
  parameter int CNT_W   = 32,
  parameter int WID_W   = 12,
  parameter int TICK_LG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             shadow_en_i,
  input  logic             load_mode_i,
  input  logic             pol_i,
  input  logic [WID_W-1:0] width_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cmp_active_o,
  output logic             match_o,
  output logic             ready_o,
  output logic             sync_o
);
  import pcs_pkg::*;

  logic hit, xfer_req, xfer;
  load_mode_e mode;

  assign mode     = load_mode_e'(load_mode_i);
  assign xfer_req = en_i & ((mode == LOAD_AT_MATCH) ? hit : (count_i == '0));

  pcs_cmp_reg #(.CNT_W(CNT_W)) u_reg (
    .clk_i, .rst_ni,
    .wr_i(cmp_wr_i), .shadow_en_i, .wdata_i(cmp_wdata_i),
    .xfer_req_i(xfer_req), .xfer_o(xfer), .active_o(cmp_active_o)
  );

  pcs_match_det #(.CNT_W(CNT_W)) u_det (
    .clk_i, .rst_ni, .en_i, .count_i,
    .active_i(cmp_active_o), .hit_o(hit), .match_o
  );

  pcs_pulse_gen #(.WID_W(WID_W), .TICK_LG(TICK_LG)) u_pulse (
    .clk_i, .rst_ni, .en_i, .trig_i(hit),
    .width_i, .pol_i, .sync_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_o <= 1'b0;
    else         ready_o <= xfer;
  end
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             shadow_en_i,
  input logic             pol_i,
  input logic             cmp_wr_i,
  input logic [CNT_W-1:0] cmp_wdata_i,
  input logic [CNT_W-1:0] cmp_active_o,
  input logic             match_o,
  input logic             ready_o,
  input logic             sync_o
);
  // R1
  direct_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr_i && !shadow_en_i) |=> (cmp_active_o == $past(cmp_wdata_i)));
  // R2
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr_i && shadow_en_i) |=> (ready_o || $stable(cmp_active_o)));
  // R6
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);
  // R7
  pulse_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (sync_o != pol_i));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!match_o && !ready_o && sync_o == pol_i));
  // R5
  ready_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(en_i));
endmodule

bind pos_cmp_sync pcs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .shadow_en_i, .pol_i, .cmp_wr_i, .cmp_wdata_i,
  .cmp_active_o, .match_o, .ready_o, .sync_o
);

// File: tb/sim_pos_cmp_sync.sv
`timescale 1ns/1ps
module sim_pos_cmp_sync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, shadow_en = 1'b0, load_mode = 1'b0, pol = 1'b0;
  logic [11:0] width = '0;
  logic [31:0] count = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] active;
  logic        match, ready, sync;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pos_cmp_sync u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .shadow_en_i(shadow_en),
    .load_mode_i(load_mode), .pol_i(pol), .width_i(width), .count_i(count),
    .cmp_wr_i(wr), .cmp_wdata_i(wdata), .cmp_active_o(active),
    .match_o(match), .ready_o(ready), .sync_o(sync)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(logic [31:0] v);
    wr = 1'b1; wdata = v;
    step();
    wr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #10;
    // R11 reset state
    chk("R11 active", active, 0);
    chk("R11 match", match, 0);
    chk("R11 ready", ready, 0);
    chk("R11 sync", sync, 0);
    rst_n = 1'b1;
    step();
    en = 1'b1; count = 100;
    // R1 direct write
    write_cmp(50);
    chk("R1 active", active, 50);
    // R6 match on first equality, once
    count = 50;
    step();
    chk("R6 match", match, 1);
    step();
    chk("R6 no repeat", match, 0);
    step();
    chk("R6 still held", match, 0);

    // R7 R8 width and polarity sweep
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 10; w++) begin
        int n;
        int wv;
        wv = (w < 8) ? w : (w == 8 ? 12 : 37);
        count = 1; width = 12'(wv); pol = p[0];
        step(); step();
        chk("R8 idle level", sync, p);
        count = 50;
        step();
        chk("R6 match in sweep", match, 1);
        count = 1;
        n = 0;
        while (sync != p[0] && n < 1000) begin
          n++;
          step();
        end
        chk("R7 pulse length", n, (wv + 1) * 4);
      end
    end
    pol = 1'b0;

    // R9 retrigger: second match two cycles later
    begin
      int n;
      width = 3; count = 1; step(); step();
      count = 50; step();        // S0
      count = 1;  step();        // S1
      count = 50; step();        // S2
      chk("R9 second match", match, 1);
      n = 3;
      count = 1;
      forever begin
        step();
        if (sync) n++; else break;
      end
      chk("R9 restarted length", n, 18);
    end

    // R2 R3 shadow, load at zero
    shadow_en = 1'b1; load_mode = 1'b0; count = 7;
    write_cmp(200);
    chk("R2 held", active, 50);
    chk("R5 no ready", ready, 0);
    count = 0;
    step();
    chk("R3 transfer at zero", active, 200);
    chk("R5 ready", ready, 1);
    step();
    chk("R5 ready one cycle", ready, 0);
    count = 50; step();
    // R3: match does not transfer in zero mode
    count = 9; write_cmp(222);
    count = 200; step();
    chk("R3 match no xfer", active, 200);
    chk("R3 match seen", match, 1);

    // R4 load at match
    load_mode = 1'b1; count = 9; step();
    write_cmp(300);
    chk("R2 held again", active, 200);
    count = 200;
    step();
    chk("R4 match", match, 1);
    chk("R4 transfer at match", active, 300);
    chk("R5 ready at match", ready, 1);
    write_cmp(400);
    count = 0; step(); step();
    chk("R4 no xfer at zero", active, 300);
    chk("R5 no ready at zero", ready, 0);
    count = 300; step();
    chk("R4 second transfer", active, 400);

    // R10 disabled
    count = 1; step();
    en = 1'b0; count = 400; step();
    chk("R10 no match", match, 0);
    chk("R10 sync inactive", sync, 0);
    pol = 1'b1; step();
    chk("R10 sync inactive low", sync, 1);
    pol = 1'b0;
    load_mode = 1'b0; count = 5;
    write_cmp(500);
    count = 0; step();
    chk("R10 no ready", ready, 0);
    chk("R10 no xfer", active, 400);
    en = 1'b1; step();
    chk("R3 xfer after enable", active, 500);
    chk("R5 ready after enable", ready, 1);

    // R1 direct write overrides pending
    count = 3; write_cmp(600);
    shadow_en = 1'b0;
    write_cmp(700);
    chk("R1 direct wins", active, 700);
    count = 0; step();
    chk("R1 pending dropped", active, 700);
    chk("R1 no ready", ready, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule